// File: doc/BRIEF.md
# Serial Bit to Word Packer

This block gathers a stream of single-bit digital samples into full-width words so that a downstream FIFO with 32-bit elements carries 32 samples in each write rather than one. On every clock cycle in which the sample qualifier is high, the new bit is shifted into an accumulator at the low end. Older bits move toward the top of the word. A small counter records how many bits the current word holds.

When the counter shows a complete word, the block offers it to the FIFO for exactly one cycle. Sampling never pauses. The bit captured in the emit cycle already belongs to the next word, so the counter restarts at one in that cycle rather than at zero. If the FIFO reports full while a word is offered, the word is discarded and a sticky overflow flag is raised. Sampling carries on without interruption.

Top module: `bitpack_top`

## Requirements
- R1: After synchronous reset, wr_en is 0 and overflow is 0, and the first word emitted holds exactly the first 32 samples accepted after reset.
- R2: In an emitted word, the earliest of its 32 samples sits in bit 31 and the latest in bit 0.
- R3: A cycle with sample_valid low changes neither the accumulated bits nor the sample count, so gaps do not alter word contents.
- R4: A word is offered in the cycle after its 32nd sample is accepted, with wr_en high for that one cycle and wr_data carrying the word.
- R5: A sample accepted in the emit cycle becomes the first (bit 31) sample of the next word, so unbroken sampling yields one word every 32 cycles with no lost or duplicated bit.
- R6: If fifo_full is high in the emit cycle, wr_en stays 0, the word is dropped, overflow becomes 1 on the next cycle, and the following word is still correct.
- R7: Once set, overflow stays 1 until reset.
- R8: fifo_full has no effect in cycles in which no word is being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Qualifies sample_bit in this cycle |
| sample_bit | input | 1 | The digital sample |
| fifo_full | input | 1 | FIFO cannot take a write this cycle |
| wr_en | output | 1 | Write strobe toward the FIFO |
| wr_data | output | 32 | Completed word |
| overflow | output | 1 | Sticky: a word was dropped |

## Verification
Two things can happen in the same cycle: a word can be emitted and the first sample of the next word can be captured, and a full FIFO can also coincide with that emit cycle. The bench keeps sample_valid high through every word boundary, and it also places gaps just before and during boundaries. It then compares each emitted word with a bench model of the packing order. This shows whether the boundary bit goes to the right word and whether any bit is lost or duplicated. Directed cycles assert fifo_full exactly in the emit cycle and check that the write is suppressed, that overflow rises and stays set, and that the next word is intact.

// File: rtl/bitpack_pkg.sv
package bitpack_pkg;

    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_CNT_W  = 8;

    typedef struct packed {
        logic valid;
        logic value;
    } sample_t;

    typedef enum logic [1:0] {
        CNT_HOLD    = 2'd0,
        CNT_INC     = 2'd1,
        CNT_RESTART = 2'd2,
        CNT_CLEAR   = 2'd3
    } cnt_op_e;

    function automatic cnt_op_e pick_cnt_op(input logic valid, input logic full);
        if (full)
            return valid ? CNT_RESTART : CNT_CLEAR;
        return valid ? CNT_INC : CNT_HOLD;
    endfunction

endpackage

// File: rtl/bitpack_shifter.sv
module bitpack_shifter #(
    parameter int unsigned WORD_W = bitpack_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bitpack_pkg::sample_t smp,
    output logic [WORD_W-1:0] acc
);
    logic [WORD_W-1:0] acc_q;
    logic              carry_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (smp.valid) begin
            acc_q   <= {acc_q[WORD_W-2:0], smp.value};
            carry_q <= acc_q[WORD_W-1];
        end
    end

    assign acc = acc_q;

    AST_GAP_HOLDS_BITS: assert property (@(posedge clk) disable iff (rst)
        !smp.valid |=> ($stable(acc_q) && $stable(carry_q))); // R3
endmodule

// File: rtl/bitpack_counter.sv
module bitpack_counter #(
    parameter int unsigned WORD_W = bitpack_pkg::DEF_WORD_W,
    parameter int unsigned CNT_W  = bitpack_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    output logic             word_full,
    output logic [CNT_W-1:0] count
);
    import bitpack_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    logic [CNT_W-1:0] cnt_q;
    cnt_op_e          op;

    assign word_full = (cnt_q == FULL_CNT);
    assign op        = pick_cnt_op(smp_valid, word_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_INC:     cnt_q <= cnt_q + CNT_W'(1);
                CNT_RESTART: cnt_q <= CNT_W'(1);
                CNT_CLEAR:   cnt_q <= '0;
                default:     cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT); // R4
    AST_RESTART_AT_ONE: assert property (@(posedge clk) disable iff (rst)
        word_full |=> (cnt_q == CNT_W'($past(smp_valid)))); // R5
    AST_COUNT_GAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !word_full) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/bitpack_emit.sv
module bitpack_emit #(
    parameter int unsigned WORD_W = bitpack_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_full,
    input  logic [WORD_W-1:0] acc,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              overflow
);
    logic ovf_q;
    logic drop;

    assign drop    = word_full & fifo_full;
    assign wr_en   = word_full & ~fifo_full;
    assign wr_data = acc;

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (drop)
            ovf_q <= 1'b1;
    end

    assign overflow = ovf_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q); // R7
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (word_full && fifo_full) |=> ovf_q); // R6
endmodule

// File: rtl/bitpack_top.sv
module bitpack_top #(
    parameter int unsigned WORD_W = bitpack_pkg::DEF_WORD_W,
    parameter int unsigned CNT_W  = bitpack_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_valid,
    input  logic              sample_bit,
    input  logic              fifo_full,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              overflow
);
    import bitpack_pkg::*;

    sample_t           smp;
    logic              word_full;
    logic [CNT_W-1:0]  count;
    logic [WORD_W-1:0] acc;

    assign smp.valid = sample_valid;
    assign smp.value = sample_bit;

    bitpack_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk (clk),
        .rst (rst),
        .smp (smp),
        .acc (acc)
    );

    bitpack_counter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (sample_valid),
        .word_full (word_full),
        .count     (count)
    );

    bitpack_emit #(.WORD_W(WORD_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .word_full (word_full),
        .acc       (acc),
        .fifo_full (fifo_full),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .overflow  (overflow)
    );

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en); // R4
    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !wr_en); // R6
    AST_EMPTY_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !wr_en); // R1
endmodule

// File: tb/bitpack_top_test.sv
module bitpack_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic        sample_bit = 1'b0;
    logic        fifo_full = 1'b0;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        overflow;

    int total = 0;
    int bad = 0;
    int words_seen = 0;
    int words_exp = 0;
    bit done = 1'b0;

    int          m_cnt = 0;
    logic [31:0] m_word = '0;
    bit          m_ovf = 1'b0;

    always #5 clk = ~clk;

    bitpack_top uut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_bit(sample_bit),
        .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] push_bit(input logic [31:0] w, input logic b);
        return {w[30:0], b};
    endfunction

    // one clock cycle: drive at negedge, check, update model
    task automatic step(input bit v, input bit b, input bit ff, input string tag);
        bit emit;
        @(negedge clk);
        sample_valid = v;
        sample_bit   = b;
        fifo_full    = ff;
        #1;
        emit = (m_cnt == 32);
        chk(wr_en == (emit && !ff), emit ? (ff ? "R6" : "R4") : "R8", "wr_en",
            {31'b0, wr_en}, {31'b0, emit && !ff});
        if (emit && !ff) begin
            chk(wr_data == m_word, tag, "wr_data", wr_data, m_word);
            words_seen++;
        end
        if (emit) words_exp++;
        chk(overflow == m_ovf, "R7", "overflow", {31'b0, overflow}, {31'b0, m_ovf});
        if (emit) begin
            if (ff) m_ovf = 1'b1;
            m_cnt = v ? 1 : 0;
        end else if (v) begin
            m_cnt++;
        end
        if (v) m_word = push_bit(m_word, b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sample_valid = 1'b0;
        fifo_full = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0;
        m_word = '0;
        m_ovf = 1'b0;
        #1;
        chk(wr_en == 1'b0, "R1", "wr_en after reset", {31'b0, wr_en}, 32'd0);
        chk(overflow == 1'b0, "R1", "overflow after reset", {31'b0, overflow}, 32'd0);
    endtask

    initial begin
        logic [31:0] pat;
        void'($urandom(32'd1234));
        do_reset();
        // R1/R2: first word, directed pattern, oldest bit first into bit 31
        pat = 32'hA5C3_0F71;
        for (int i = 31; i >= 0; i--) step(1'b1, pat[i], 1'b0, "R2");
        // R5: continuous sampling across boundary, word of alternating bits
        pat = 32'h8000_0001;
        for (int i = 31; i >= 0; i--) step(1'b1, pat[i], 1'b0, "R5");
        for (int i = 31; i >= 0; i--) step(1'b1, i[0], 1'b0, "R5");
        // R3: gaps, including a gap in the emit cycle
        step(1'b0, 1'b1, 1'b0, "R3");
        for (int i = 0; i < 40; i++) step(i % 3 != 0, i[1], 1'b0, "R3");
        // R8: fifo_full outside emit cycles
        for (int i = 0; i < 70; i++) step(1'b1, i[2], (m_cnt != 32), "R8");
        // R6: drop a word, then keep sampling
        while (m_cnt != 32) step(1'b1, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b1, "R6");
        for (int i = 0; i < 64; i++) step(1'b1, i[0] ^ i[3], 1'b0, "R6");
        // R7: overflow persists
        chk(overflow == 1'b1, "R7", "sticky overflow", {31'b0, overflow}, 32'd1);
        // random phase
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) != 0, $urandom % 2, ($urandom % 8) == 0, "R2");
        // reset clears overflow and restarts cleanly
        do_reset();
        for (int i = 0; i < 200; i++)
            step(($urandom % 5) != 0, $urandom % 2, 1'b0, "R1");
        chk(words_seen > 0, "R5", "words emitted", words_seen, words_exp);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule